// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Shared Prescaler

This block drives a small bank of pulse-width-modulated outputs that all run from one common timebase. An 8-bit prescaler divides the input clock into ticks. An 8-bit period counter steps through 256 ticks and then wraps, so the period is always 256 ticks. The only way to change the period is to change the prescaler. Each channel compares the shared counter against its own duty value and drives one output pin. A single enable bit starts or stops the whole bank.

Software programs the block through a simple 32-bit register bus with word-aligned offsets. A duty value `D` gives a high time of `D+1` ticks at the start of each period. The top value therefore keeps the pin high all the time. New duty values are held in a staging register and copied to the compare logic only at the period boundary, so a period in progress keeps its width. The channel count is a parameter from 1 to 4.

Top module: `pwm_bank`

## Requirements
- R1: All channels share one 8-bit period counter that advances once per tick and wraps from 255 to 0. A tick lasts `P+1` clocks, where `P` is the 8-bit prescale value, so every output repeats every `256*(P+1)` clocks.
- R2: The control register is at byte offset 0x50. The low nibble of `P` is bits 3:0 and the high nibble of `P` is bits 14:11.
- R3: Channel `n` has an 8-bit duty register at byte offset `4*n`. With duty `D` below 255, the output goes high at the start of each period and stays high for `(D+1)*(P+1)` clocks, so duty 0 gives a single tick.
- R4: A duty of 255 holds the output high for the whole period, so it never drops while the bank is enabled.
- R5: Bit 9 of the control register enables the bank. While it is 0, every output is low and the prescaler and period counter are held at zero. After it is set, each output rises one clock later and the first period is a complete one.
- R6: A write to a duty register while the bank is running changes nothing until the period counter next wraps to 0. The period in progress keeps its old high time, and the following period uses the new value.
- R7: A read returns, on `bus_rdata` one clock after `bus_rd`, the last value written to the implemented fields of that register. Every other bit reads as 0. A duty write keeps only bits 7:0.
- R8: A duty offset for a channel that is not implemented, or any unmapped offset, reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one clock after `bus_rd` |
| pwm_out | output | NCH | Registered PWM outputs, one bit per channel |

## Verification
The bench measures high time and period edge to edge and checks them against the formula for several duty and prescale values. One of these uses a prescale with only the high nibble set: a design that misplaces the split field produces a 256-clock period instead of 4352 clocks.

Duty 0 and duty 254 test the compare boundary, where an off-by-one gives zero or two ticks, or a pin stuck high. Duty 255 tests that the pin never drops.

To test the staging register, the bench rewrites a duty value in the middle of a pulse. A design without staging would stretch that pulse at once.

Turning the bank off and on again tests that the outputs go low and that the counter restarts at zero. A design that only gates the pins would resume mid-period with a clipped first pulse. Reads of the unimplemented fourth channel and of an unmapped offset must return 0.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned PS_W    = 8;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h50;
  localparam int unsigned PS_LO_LSB = 0;
  localparam int unsigned PS_HI_LSB = 11;
  localparam int unsigned EN_POS    = 9;

  typedef struct packed {
    logic            en;
    logic [PS_W-1:0] ps;
  } bank_ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output bank_ctrl_t            ctrl,
  output logic [NCH*CNT_W-1:0]  duty_flat
);
  localparam int unsigned IDX_W = 2;

  logic [IDX_W-1:0] idx;
  logic             duty_zone;
  logic             ctrl_hit;
  logic [NCH-1:0]   duty_hit;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_wbits;

  assign idx       = bus_addr[IDX_W+1:2];
  assign duty_zone = (bus_addr[ADDR_W-1:IDX_W+2] == '0) && (bus_addr[1:0] == 2'b00);
  assign ctrl_hit  = (bus_addr == CTRL_OFS);
  assign unused_wbits = ^{bus_wdata[31:15], bus_wdata[10], bus_wdata[8], bus_wdata[7:4]};

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_duty
      logic [CNT_W-1:0] duty_q;
      assign duty_hit[g] = duty_zone && (idx == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (rst) duty_q <= '0;
        else if (bus_wr && duty_hit[g]) duty_q <= bus_wdata[CNT_W-1:0];
      end
      assign duty_flat[g*CNT_W +: CNT_W] = duty_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (bus_wr && ctrl_hit) begin
      ctrl.en <= bus_wdata[EN_POS];
      ctrl.ps <= {bus_wdata[PS_HI_LSB +: 4], bus_wdata[PS_LO_LSB +: 4]};
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) begin
      rd_mux[PS_LO_LSB +: 4] = ctrl.ps[3:0];
      rd_mux[PS_HI_LSB +: 4] = ctrl.ps[7:4];
      rd_mux[EN_POS]         = ctrl.en;
    end
    for (int i = 0; i < NCH; i++) begin
      if (duty_hit[i]) rd_mux[CNT_W-1:0] = duty_flat[i*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R7: bits outside all defined fields always read back as zero
  assert_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(bus_rd) |-> (bus_rdata[31:15] == '0 && bus_rdata[10] == 1'b0 && bus_rdata[8] == 1'b0));

  // R8: a write that hits no register leaves the control fields untouched
  assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(bus_wr) && $past(bus_addr) == 8'h40 |-> $stable(ctrl));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PS_W-1:0]  ps,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [PS_W-1:0] pre;
  logic            tick;

  assign tick = (pre >= ps);
  assign wrap = en && tick && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre <= '0;
      cnt <= '0;
    end else if (tick) begin
      pre <= '0;
      cnt <= cnt + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R1: the shared counter either holds or steps by exactly one (mod 256)
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(en) && en |-> (cnt == $past(cnt) || cnt == $past(cnt) + 8'd1));

  // R5: disabling clears the timebase on the next edge
  assert_idle_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && pre == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_in,
  output logic             out_q
);
  logic [CNT_W-1:0] duty_act;

  always_ff @(posedge clk) begin
    if (rst) duty_act <= '0;
    else if (!en || wrap) duty_act <= duty_in;
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= en && (cnt <= duty_act);
  end

  // R6: the active duty only moves at a period boundary while running
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(en) && !$past(wrap) |-> $stable(duty_act));

  // R4: full-scale duty keeps the pin high
  assert_full_high_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(en) && $past(duty_act) == 8'hFF |-> out_q);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  bank_ctrl_t           ctrl;
  logic [NCH*CNT_W-1:0] duty_flat;
  logic [CNT_W-1:0]     cnt;
  logic                 wrap;

  pwm_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl(ctrl), .duty_flat(duty_flat)
  );

  pwm_timebase u_tb (
    .clk(clk), .rst(rst), .en(ctrl.en), .ps(ctrl.ps), .cnt(cnt), .wrap(wrap)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      pwm_chan u_ch (
        .clk(clk), .rst(rst), .en(ctrl.en), .wrap(wrap), .cnt(cnt),
        .duty_in(duty_flat[g*CNT_W +: CNT_W]), .out_q(pwm_out[g])
      );
    end
  endgenerate

  // R5: a disabled bank drives every pin low
  assert_off_low_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(ctrl.en) |-> pwm_out == '0);
endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  always #10 clk = ~clk;

  pwm_bank #(.NCH(NCH)) i_pwm_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  int n_checks = 0;
  int n_fail = 0;

  typedef struct { string req; int hi; int per; } exp_t;
  exp_t exp_q[$];

  task automatic chk(string req, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // scoreboard monitor
  int  mon_ch = 0;
  bit  arm_req = 0;
  bit  started = 0;
  bit  prev_lvl = 0;
  int  per_cnt = 0, hi_run = 0;

  always @(negedge clk) begin
    bit cur;
    cur = pwm_out[mon_ch];
    if (arm_req) begin
      started = 0; arm_req = 0; prev_lvl = cur;
    end else begin
      if (cur && !prev_lvl) begin
        if (started && exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.req, " high"}, hi_run, e.hi);
          chk({e.req, " period"}, per_cnt, e.per);
        end
        started = 1; per_cnt = 0; hi_run = 0;
      end
      per_cnt++;
      if (cur) hi_run++;
      prev_lvl = cur;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(bit en, logic [7:0] ps);
    return (32'(ps[7:4]) << 11) | (32'(en) << 9) | 32'(ps[3:0]);
  endfunction

  task automatic measure(int ch, string req, int duty, int ps, int n);
    mon_ch = ch; arm_req = 1;
    for (int i = 0; i < n; i++) begin
      exp_t e; e.req = req; e.hi = (duty + 1) * (ps + 1); e.per = 256 * (ps + 1);
      exp_q.push_back(e);
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk("R5 reset outputs low", int'(pwm_out), 0);
    bus_read(8'h50, rd); chk("R7 reset control", int'(rd), 0);
    bus_read(8'h00, rd); chk("R7 reset duty0", int'(rd), 0);

    // register field layout
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_read(8'h50, rd); chk("R2 R7 control fields", int'(rd), 32'h7A0F);
    bus_write(8'h50, 32'h0);
    bus_write(8'h04, 32'h0000_ABCD);
    bus_read(8'h04, rd); chk("R7 duty keeps low byte", int'(rd), 32'hCD);
    bus_write(8'h0C, 32'h55);
    bus_read(8'h0C, rd); chk("R8 missing channel reads 0", int'(rd), 0);
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_read(8'h40, rd); chk("R8 unmapped reads 0", int'(rd), 0);
    bus_read(8'h50, rd); chk("R8 unmapped write ignored", int'(rd), 0);

    // basic duty patterns, prescale 0
    bus_write(8'h00, 0);
    bus_write(8'h04, 100);
    bus_write(8'h08, 254);
    bus_write(8'h50, ctrl_word(1, 8'd0));
    measure(0, "R3 duty0", 0, 0, 2);
    measure(1, "R3 duty100", 100, 0, 2);
    measure(2, "R3 duty254", 254, 0, 2);

    // low nibble prescale
    bus_write(8'h00, 9);
    bus_write(8'h50, ctrl_word(1, 8'd2));
    measure(0, "R1 ps2", 9, 2, 2);

    // high nibble prescale only
    bus_write(8'h00, 3);
    bus_write(8'h50, ctrl_word(1, 8'h10));
    measure(0, "R2 ps16", 3, 16, 2);

    // full scale
    bus_write(8'h50, ctrl_word(1, 8'd0));
    bus_write(8'h00, 255);
    repeat (300) @(negedge clk);
    begin
      int lows = 0;
      for (int i = 0; i < 600; i++) begin @(negedge clk); if (!pwm_out[0]) lows++; end
      chk("R4 duty255 low samples", lows, 0);
    end

    // shadowed update mid pulse
    bus_write(8'h00, 50);
    repeat (600) @(negedge clk);
    mon_ch = 0; arm_req = 1;
    begin
      exp_t e;
      e.req = "R6 old width kept"; e.hi = 51;  e.per = 256; exp_q.push_back(e);
      e.req = "R6 new width next";  e.hi = 201; e.per = 256; exp_q.push_back(e);
    end
    @(negedge clk);
    while (!(pwm_out[0] == 1'b1)) @(negedge clk);
    repeat (10) @(negedge clk);
    bus_write(8'h00, 200);
    while (exp_q.size() != 0) @(negedge clk);

    // disable and restart
    bus_write(8'h00, 255);
    bus_write(8'h04, 100);
    bus_write(8'h50, ctrl_word(0, 8'd0));
    @(negedge clk);
    begin
      int highs = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (pwm_out != 0) highs++; end
      chk("R5 disabled high samples", highs, 0);
    end
    bus_write(8'h50, ctrl_word(1, 8'd0));
    @(negedge clk);
    chk("R5 all rise after enable", int'(pwm_out), 7);
    begin
      int hi1 = 0;
      while (pwm_out[1]) begin hi1++; @(negedge clk); end
      chk("R5 first pulse full width", hi1, 101);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule